// File: doc/BRIEF.md
# Streaming MD5 Message Padder

This block turns a byte stream into the padded block sequence that an MD5 compression core consumes. Message bytes arrive one per transfer on a valid/ready input, and a last flag marks the final byte. The block gathers 64 bytes at a time and sends each full block out as sixteen 32-bit words on a valid/ready output.

When a message ends, the block appends the marker byte 0x80, zero fill, and the 64-bit message length in bits. If the tail leaves no room for the length, the block sends one more block. Words are packed in the little-endian byte order that MD5 expects, so a hashing core can take them directly.

An empty message is signalled by a single input transfer with both the last flag and the empty flag set. That transfer carries no data byte. While a block is being sent out, the input is stalled.

Top module: `md5_stream_padder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Byte k of a block (k = 0..63, counted in stream order) is carried in word k/4, bits [8*(k%4)+7 : 8*(k%4)]. Words leave in order 0 to 15.
- R3: In the final block that holds data, the byte directly after the last data byte is 0x80. All bytes after it are 0x00, up to the start of the length field or the end of the block.
- R4: In the block that ends a message, bytes 56..63 hold the message length in bits (8 times the byte count), stored modulo 2^64. Word 14 carries the low 32 bits and word 15 the high 32 bits.
- R5: Every 64 data bytes that come before the end of a message are sent out unchanged as one block.
- R6: If 56 to 63 bytes of the final block are used when the message ends, the block with the marker has no length field and is zero to its end. A second block follows that is all zeros except for the length field.
- R7: If the message length is a multiple of 64 bytes and not zero, an extra block follows the last data block. That extra block starts with 0x80, is zero up to byte 55, and ends with the length.
- R8: A transfer with `in_last` = 1 and `in_empty` = 1 ends the message without adding a byte. A message made of only that transfer yields one block: 0x80 at byte 0, zeros after it, and a length of 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` keep their values into the next cycle.
- R10: `in_ready` is 0 in every cycle where `out_valid` is 1. After the last transfer of a message, the next cycle has `out_valid` = 1.
- R11: The bit count advances by 8 for each accepted data byte and restarts at zero after a message's final block. Each message's length field counts only that message's own bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Block accepts an input transfer |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | This transfer ends the message |
| in_empty | input | 1 | With `in_last`: the transfer carries no byte |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Block word, little-endian byte lanes |

## Verification
The assertions take the input side to follow valid/ready rules and `in_empty` to be set only together with `in_last`. The stall assertion also relies on `out_ready` being driven to a defined level in every cycle after reset. The stimulus drives every input at the falling edge and holds a transfer until the design has seen `in_ready`. It raises `in_empty` only on the closing transfer of an empty message. `out_ready` follows a pseudo-random stall pattern that is always a clean 0 or 1. The message lengths sit on both sides of the 55/56-byte and 64-byte boundaries, and messages follow each other directly.

// File: rtl/md5pad_pkg.sv
package md5pad_pkg;
  localparam int BYTE_W       = 8;
  localparam int WORD_BYTES   = 4;
  localparam int WORD_W       = BYTE_W * WORD_BYTES;
  localparam int BLK_WORDS    = 16;
  localparam int BLK_BYTES    = BLK_WORDS * WORD_BYTES;
  localparam int LEN_W        = 64;
  localparam int LEN_BYTES    = LEN_W / BYTE_W;
  localparam int LEN_START    = BLK_BYTES - LEN_BYTES;
  localparam int PTR_W        = $clog2(BLK_BYTES) + 1;
  localparam int ADDR_W       = $clog2(BLK_BYTES);
  localparam int WIDX_W       = $clog2(BLK_WORDS);
  localparam int LANE_W       = $clog2(WORD_BYTES);
  localparam int LEN_LO_WORD  = BLK_WORDS - 2;
  localparam int LEN_HI_WORD  = BLK_WORDS - 1;
  localparam logic [BYTE_W-1:0] MARK_BYTE = 8'h80;

  typedef enum logic {ST_FILL = 1'b0, ST_EMIT = 1'b1} pad_state_t;

  // Block descriptor: bytes below fill are data, mark places the 0x80
  // byte at index fill, with_len inserts the length into the last 8 bytes.
  typedef struct packed {
    logic [PTR_W-1:0] fill;
    logic             mark;
    logic             with_len;
  } blk_desc_t;

  typedef struct packed {
    blk_desc_t first;
    logic      spill;
    logic      spill_mark;
  } tail_plan_t;

  // Value of byte idx of an outgoing block, length field aside.
  function automatic logic [BYTE_W-1:0] pad_byte(
      input logic [BYTE_W-1:0] stored,
      input logic [PTR_W-1:0]  idx,
      input logic [PTR_W-1:0]  fill,
      input logic              mark);
    if (idx < fill)               return stored;
    else if (mark && idx == fill) return MARK_BYTE;
    else                          return '0;
  endfunction

  // Choose how the end of a message is laid out, given bytes used.
  function automatic tail_plan_t plan_tail(input logic [PTR_W-1:0] used);
    tail_plan_t p;
    p.first.fill = used;
    p.spill_mark = 1'b0;
    if (used < PTR_W'(LEN_START)) begin
      p.first.mark     = 1'b1;
      p.first.with_len = 1'b1;
      p.spill          = 1'b0;
    end else if (used < PTR_W'(BLK_BYTES)) begin
      p.first.mark     = 1'b1;
      p.first.with_len = 1'b0;
      p.spill          = 1'b1;
    end else begin
      p.first.mark     = 1'b0;
      p.first.with_len = 1'b0;
      p.spill          = 1'b1;
      p.spill_mark     = 1'b1;
    end
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] len_word(
      input logic [LEN_W-1:0] len, input logic hi);
    return hi ? len[LEN_W-1:WORD_W] : len[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/md5pad_bitcount.sv
module md5pad_bitcount
  import md5pad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic             clr,
  output logic [LEN_W-1:0] count
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(BYTE_W);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (add_en) count <= count + STEP;
  end
endmodule

// File: rtl/md5pad_blockbuf.sv
module md5pad_blockbuf
  import md5pad_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [WIDX_W-1:0] rd_idx,
  input  blk_desc_t         desc,
  input  logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] rd_word
);
  logic [BYTE_W-1:0] mem [BLK_BYTES];
  logic [WORD_W-1:0] raw_word;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_byte;
  end

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    logic [PTR_W-1:0] idx;
    assign idx = {1'b0, rd_idx, LANE_W'(b)};
    assign raw_word[b*BYTE_W +: BYTE_W] =
      pad_byte(mem[idx[ADDR_W-1:0]], idx, desc.fill, desc.mark);
  end

  always_comb begin
    if (desc.with_len && rd_idx == WIDX_W'(LEN_LO_WORD))
      rd_word = len_word(len, 1'b0);
    else if (desc.with_len && rd_idx == WIDX_W'(LEN_HI_WORD))
      rd_word = len_word(len, 1'b1);
    else
      rd_word = raw_word;
  end
endmodule

// File: rtl/md5pad_seq.sv
module md5pad_seq
  import md5pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_empty,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [WIDX_W-1:0] rd_idx,
  output blk_desc_t         desc,
  output logic              in_fire,
  output logic              byte_fire,
  output logic              out_fire,
  output logic              blk_done,
  output logic              msg_done
);
  pad_state_t        state;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  fill_next;
  logic              pend;
  logic              pend_mark;
  tail_plan_t        tail;

  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign byte_fire = in_fire && !(in_last && in_empty);
  assign out_fire  = out_valid && out_ready;
  assign blk_done  = out_fire && (rd_idx == WIDX_W'(BLK_WORDS - 1));
  assign msg_done  = blk_done && desc.with_len;
  assign wr_en     = byte_fire;
  assign wr_ptr    = ptr[ADDR_W-1:0];
  assign fill_next = ptr + PTR_W'(byte_fire);
  assign tail      = plan_tail(fill_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      ptr       <= '0;
      rd_idx    <= '0;
      desc      <= '0;
      pend      <= 1'b0;
      pend_mark <= 1'b0;
    end else begin
      case (state)
        ST_FILL: begin
          if (in_fire) begin
            if (in_last) begin
              state     <= ST_EMIT;
              rd_idx    <= '0;
              desc      <= tail.first;
              pend      <= tail.spill;
              pend_mark <= tail.spill_mark;
            end else if (fill_next == PTR_W'(BLK_BYTES)) begin
              state         <= ST_EMIT;
              rd_idx        <= '0;
              desc.fill     <= fill_next;
              desc.mark     <= 1'b0;
              desc.with_len <= 1'b0;
              pend          <= 1'b0;
            end else begin
              ptr <= fill_next;
            end
          end
        end
        ST_EMIT: begin
          if (out_fire) rd_idx <= rd_idx + 1'b1;
          if (blk_done) begin
            if (pend) begin
              desc.fill     <= '0;
              desc.mark     <= pend_mark;
              desc.with_len <= 1'b1;
              pend          <= 1'b0;
            end else begin
              state <= ST_FILL;
              ptr   <= '0;
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/md5_stream_padder.sv
module md5_stream_padder
  import md5pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_empty,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_ptr;
  logic [WIDX_W-1:0] word_idx;
  blk_desc_t         desc;
  logic              in_fire;
  logic              byte_fire;
  logic              out_fire;
  logic              blk_done;
  logic              msg_done;
  logic [LEN_W-1:0]  bit_cnt;

  md5pad_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_empty  (in_empty),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .rd_idx    (word_idx),
    .desc      (desc),
    .in_fire   (in_fire),
    .byte_fire (byte_fire),
    .out_fire  (out_fire),
    .blk_done  (blk_done),
    .msg_done  (msg_done)
  );

  md5pad_bitcount u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .add_en (byte_fire),
    .clr    (msg_done),
    .count  (bit_cnt)
  );

  md5pad_blockbuf u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_byte (in_data),
    .rd_idx  (word_idx),
    .desc    (desc),
    .len     (bit_cnt),
    .rd_word (out_data)
  );
endmodule

// File: rtl/md5pad_checker.sv
module md5pad_checker
  import md5pad_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              in_fire,
  input logic              byte_fire,
  input logic              out_fire,
  input logic              blk_done,
  input logic              msg_done,
  input logic [WIDX_W-1:0] word_idx,
  input logic [LEN_W-1:0]  bit_cnt
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_last) |=> (out_valid && !in_ready));

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |=> (bit_cnt == $past(bit_cnt) + LEN_W'(BYTE_W)));

  assert_count_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> (bit_cnt == '0 && in_ready && !out_valid));

  assert_word_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !blk_done) |=> (word_idx == $past(word_idx) + 1'b1));

  assert_count_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !msg_done) |=> $stable(bit_cnt));
endmodule

bind md5_stream_padder md5pad_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .in_fire   (in_fire),
  .byte_fire (byte_fire),
  .out_fire  (out_fire),
  .blk_done  (blk_done),
  .msg_done  (msg_done),
  .word_idx  (word_idx),
  .bit_cnt   (bit_cnt)
);

// File: tb/tb_md5_stream_padder.sv
module tb_md5_stream_padder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_empty = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mon_lfsr = 16'hACE1;
  logic [15:0] drv_lfsr = 16'h1D2B;
  bit          always_ready = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  md5_stream_padder dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [7:0] msg_byte(input int k, input int seed);
    return 8'((k * 7 + seed * 13 + 1) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input bit last, input bit empty);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_empty = empty;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_empty = 1'b0;
  endtask

  // Reference: message bytes, 0x80, zeros, 8 length bytes little-endian.
  task automatic send_msg(input int n, input int seed, input string tag);
    int total;
    logic [63:0] bits;
    total = ((n + 8) / 64 + 1) * 64;
    bits  = 64'(n) * 64'd8;
    for (int w = 0; w < total / 4; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) begin
        int k;
        logic [7:0] v;
        k = 4 * w + b;
        if (k < n)               v = msg_byte(k, seed);
        else if (k == n)         v = 8'h80;
        else if (k >= total - 8) v = 8'(bits >> (8 * (k - (total - 8))));
        else                     v = 8'h00;
        word[8*b +: 8] = v;
      end
      exp_q.push_back(word);
      tag_q.push_back($sformatf("%s len=%0d word=%0d", tag, n, w));
    end
    if (n == 0) begin
      put(8'h5A, 1'b1, 1'b1);
    end else begin
      for (int k = 0; k < n; k++) begin
        put(msg_byte(k, seed), k == n - 1, 1'b0);
        drv_lfsr = step(drv_lfsr);
        if (drv_lfsr[0] && drv_lfsr[3] && k != n - 1) idle_in();
      end
    end
    idle_in();
  endtask

  // Monitor and scoreboard.
  initial begin : monitor
    bit          was_stalled;
    logic [31:0] held;
    was_stalled = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      mon_lfsr = step(mon_lfsr);
      out_ready = always_ready | mon_lfsr[1] | mon_lfsr[4];
      #1;
      if (rst_n) begin
        if (was_stalled)
          check(out_valid && out_data == held, "R9 hold", {31'd0, out_valid, out_data},
                {32'd1, held});
        was_stalled = out_valid && !out_ready;
        held = out_data;
        if (out_valid && in_ready)
          check(1'b0, "R10 in_ready during output", 64'(in_ready), 64'd0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected word", 64'(out_data), 64'd0);
          end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data == e, t, 64'(out_data), 64'(e));
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 first cycle",
          {out_valid, in_ready}, 2'b01);

    send_msg(0,   1, "R8 empty");
    send_msg(1,   2, "R3 one byte");
    send_msg(3,   3, "R2 three bytes");
    send_msg(55,  4, "R4 longest single block");
    send_msg(56,  5, "R6 spill at 56");
    send_msg(57,  6, "R6 spill at 57");
    send_msg(63,  7, "R6 spill at 63");
    send_msg(64,  8, "R7 exact block");
    always_ready = 1'b1;
    send_msg(65,  9, "R5 one block plus one");
    send_msg(5,  10, "R11 short after long");
    always_ready = 1'b0;
    send_msg(119, 11, "R5 two blocks tail 55");
    send_msg(120, 12, "R6 two blocks tail 56");
    send_msg(128, 13, "R7 two exact blocks");
    send_msg(200, 14, "R4 long");
    send_msg(0,   15, "R8 empty again");

    wait (exp_q.size() == 0);
    repeat (6) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 no extra output", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R11 ready for next message", 64'(in_ready), 64'd1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule